// File: doc/BRIEF.md
# Anode Stub Pattern Finder

This block looks for short straight track segments ("stubs") in a six-layer wire chamber. Once per bunch crossing it receives one hit bit per layer per wire group. For every wire group it treats that group as the key position on layer index 1, the second layer. Around that key it counts how many layers hold at least one hit inside two shapes. The collision shape is symmetric. The accelerator shape leans to one side, toward higher wire groups.

The decision is made in two steps. A low pretrigger threshold starts a per-group wait of a programmable number of crossings. At the end of the wait the layer count is taken again and compared against a trigger threshold. Groups that pass become candidates. The block reports up to two of them per crossing, ranked by:
1. layer count;
2. collision shape before accelerator shape;
3. lower wire group.

The second stub must sit more than one group away from the first. Thresholds, wait length and the accelerator enable come in on static configuration inputs.

Top module: `anode_stub_finder`

## Requirements
- R1: While rst_ni is low and on the first cycle after release, every stub output is 0.
- R2: The collision count for key group k is the number of layers l (0..5) with a hit on k itself when l is 1, or with a hit on any of k-1, k, k+1 when l is not 1. The hit bit for layer l, group w is hits_i[l*NUM_WG+w]. A reported count lies in 1..6.
- R3: The accelerator count for key group k is the number of layers with a hit on k itself when l is 1, or with a hit on any of k, k+1, k+2 when l is not 1.
- R4: A key group that is not waiting pretriggers in a crossing when its collision count, or its accelerator count with the accelerator enable set, is at least cfg_pre_thr_i (1..6). Without a pretrigger no stub is produced for that group.
- R5: For a pretrigger at crossing t with cfg_delay_i = d, the counts are taken again at crossing t+d (d = 0 means the same crossing). A stub from crossing t+d appears on the outputs two clock edges after that crossing's hits are applied.
- R6: At the evaluation crossing a shape qualifies only if its count is at least cfg_trig_thr_i (1..6). If both shapes qualify, the one with the higher count is taken, and the collision shape on a tie. A qualifying group gives exactly one candidate.
- R7: While a group waits (d > 0), further pretriggers in that group are ignored until its evaluation crossing has passed.
- R8: The first stub is the candidate with the highest count. Among equal counts a collision candidate (stub acc bit 0) beats an accelerator candidate (acc bit 1), and after that the lower key group wins.
- R9: The second stub is the best remaining candidate, ranked as in R8, whose key group differs from the first stub's by more than one. It is never valid when the first stub is not.
- R10: With cfg_acc_en_i low, accelerator counts neither pretrigger nor trigger, and no stub has its acc bit set.
- R11: A stub whose valid bit is 0 shows 0 on its group, acc and count outputs.
- R12: Positions beyond group 0 and group NUM_WG-1 hold no hits, so the shapes are truncated at both edges of the chamber.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hits_i | input | 6*NUM_WG | Hit bits, layer l group w at bit l*NUM_WG+w |
| cfg_pre_thr_i | input | 3 | Pretrigger layer threshold, 1..6 |
| cfg_trig_thr_i | input | 3 | Trigger layer threshold, 1..6 |
| cfg_delay_i | input | DLY_W | Crossings from pretrigger to evaluation |
| cfg_acc_en_i | input | 1 | Allow accelerator shape |
| stub0_valid_o | output | 1 | First stub present |
| stub0_wg_o | output | $clog2(NUM_WG) | First stub key group |
| stub0_acc_o | output | 1 | First stub shape, 1 = accelerator |
| stub0_cnt_o | output | 3 | First stub layer count |
| stub1_valid_o | output | 1 | Second stub present |
| stub1_wg_o | output | $clog2(NUM_WG) | Second stub key group |
| stub1_acc_o | output | 1 | Second stub shape, 1 = accelerator |
| stub1_cnt_o | output | 3 | Second stub layer count |

## Verification
The bench builds the block with NUM_WG = 12. That is not a power of two, so the group index has codes no group uses, and the two chamber edges lie within reach of random tracks and of stimulus aimed at the edges. DLY_W = 3 allows waits from 0, where the evaluation happens in the pretrigger crossing itself, up to 7 crossings. Long waits under dense hits exercise the case where new pretriggers are ignored while a group is waiting. Low and high thresholds, both settings of the accelerator enable, and dense hit patterns that produce many equal-count ties all occur within the run.

// File: rtl/anode_stub_pkg.sv
package anode_stub_pkg;
  localparam int NLAYERS   = 6;
  localparam int KEY_LAYER = 1;
  localparam int CNT_W     = 3;

  typedef logic [CNT_W-1:0] lcnt_t;

  typedef struct packed {
    logic  valid;
    logic  acc;
    lcnt_t cnt;
  } cand_t;
endpackage

// File: rtl/stub_layer_count.sv
module stub_layer_count
  import anode_stub_pkg::*;
#(
  parameter int NUM_WG = 16
) (
  input  logic [NLAYERS*NUM_WG-1:0] hits_i,
  output lcnt_t                     col_cnt_o [NUM_WG],
  output lcnt_t                     acc_cnt_o [NUM_WG]
);
  for (genvar k = 0; k < NUM_WG; k++) begin : g_key
    logic [NLAYERS-1:0] col_lyr, acc_lyr;

    always_comb begin
      col_lyr = '0;
      acc_lyr = '0;
      for (int l = 0; l < NLAYERS; l++) begin
        for (int o = -1; o <= 2; o++) begin
          if ((k + o >= 0) && (k + o < NUM_WG)) begin
            if ((l == KEY_LAYER) ? (o == 0) : (o <= 1))
              col_lyr[l] = col_lyr[l] | hits_i[l*NUM_WG + k + o];
            if ((l == KEY_LAYER) ? (o == 0) : (o >= 0))
              acc_lyr[l] = acc_lyr[l] | hits_i[l*NUM_WG + k + o];
          end
        end
      end
    end

    assign col_cnt_o[k] = lcnt_t'($countones(col_lyr));
    assign acc_cnt_o[k] = lcnt_t'($countones(acc_lyr));
  end
endmodule

// File: rtl/stub_trig_seq.sv
module stub_trig_seq
  import anode_stub_pkg::*;
#(
  parameter int NUM_WG = 16,
  parameter int DLY_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lcnt_t            col_cnt_i [NUM_WG],
  input  lcnt_t            acc_cnt_i [NUM_WG],
  input  lcnt_t            pre_thr_i,
  input  lcnt_t            trig_thr_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             acc_en_i,
  output cand_t            cand_o [NUM_WG]
);
  for (genvar k = 0; k < NUM_WG; k++) begin : g_seq
    logic [DLY_W-1:0] timer_q;
    logic             pre, eval, col_ok, acc_ok;
    cand_t            cand;

    always_comb begin
      pre    = (timer_q == '0) &&
               ((col_cnt_i[k] >= pre_thr_i) || (acc_en_i && (acc_cnt_i[k] >= pre_thr_i)));
      eval   = (timer_q == DLY_W'(1)) || (pre && (delay_i == '0));
      col_ok = eval && (col_cnt_i[k] >= trig_thr_i);
      acc_ok = eval && acc_en_i && (acc_cnt_i[k] >= trig_thr_i);
      cand   = '0;
      if (col_ok && (!acc_ok || (col_cnt_i[k] >= acc_cnt_i[k]))) begin
        cand.valid = 1'b1;
        cand.cnt   = col_cnt_i[k];
      end else if (acc_ok) begin
        cand.valid = 1'b1;
        cand.acc   = 1'b1;
        cand.cnt   = acc_cnt_i[k];
      end
    end

    // wait timer: counts down to the evaluation crossing
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      timer_q <= '0;
      else if (pre && (delay_i != '0))  timer_q <= delay_i;
      else if (timer_q != '0)           timer_q <= timer_q - DLY_W'(1);
    end

    assign cand_o[k] = cand;
  end
endmodule

// File: rtl/stub_rank.sv
module stub_rank
  import anode_stub_pkg::*;
#(
  parameter int NUM_WG = 16,
  parameter int WG_W   = 4
) (
  input  cand_t           cand_i [NUM_WG],
  output cand_t           best0_o,
  output logic [WG_W-1:0] wg0_o,
  output cand_t           best1_o,
  output logic [WG_W-1:0] wg1_o
);
  function automatic logic beats(cand_t a, cand_t b);
    if (!a.valid)       return 1'b0;
    if (!b.valid)       return 1'b1;
    if (a.cnt != b.cnt) return a.cnt > b.cnt;
    return !a.acc && b.acc;
  endfunction

  always_comb begin
    best0_o = '0;
    wg0_o   = '0;
    for (int k = 0; k < NUM_WG; k++) begin
      if (beats(cand_i[k], best0_o)) begin
        best0_o = cand_i[k];
        wg0_o   = WG_W'(k);
      end
    end
    best1_o = '0;
    wg1_o   = '0;
    for (int k = 0; k < NUM_WG; k++) begin
      if (best0_o.valid && ((k > int'(wg0_o) + 1) || (k + 1 < int'(wg0_o))) &&
          beats(cand_i[k], best1_o)) begin
        best1_o = cand_i[k];
        wg1_o   = WG_W'(k);
      end
    end
  end
endmodule

// File: rtl/anode_stub_finder.sv
module anode_stub_finder
  import anode_stub_pkg::*;
#(
  parameter  int NUM_WG = 16,
  parameter  int DLY_W  = 3,
  localparam int WG_W   = $clog2(NUM_WG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NLAYERS*NUM_WG-1:0] hits_i,
  input  logic [CNT_W-1:0]          cfg_pre_thr_i,
  input  logic [CNT_W-1:0]          cfg_trig_thr_i,
  input  logic [DLY_W-1:0]          cfg_delay_i,
  input  logic                      cfg_acc_en_i,
  output logic                      stub0_valid_o,
  output logic [WG_W-1:0]           stub0_wg_o,
  output logic                      stub0_acc_o,
  output logic [CNT_W-1:0]          stub0_cnt_o,
  output logic                      stub1_valid_o,
  output logic [WG_W-1:0]           stub1_wg_o,
  output logic                      stub1_acc_o,
  output logic [CNT_W-1:0]          stub1_cnt_o
);
  logic [NLAYERS*NUM_WG-1:0] hits_q;
  lcnt_t                     col_cnt [NUM_WG];
  lcnt_t                     acc_cnt [NUM_WG];
  cand_t                     cand    [NUM_WG];
  cand_t                     best0, best1;
  logic [WG_W-1:0]           wg0, wg1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hits_q <= '0;
    else         hits_q <= hits_i;
  end

  stub_layer_count #(.NUM_WG(NUM_WG)) i_count (
    .hits_i    (hits_q),
    .col_cnt_o (col_cnt),
    .acc_cnt_o (acc_cnt)
  );

  stub_trig_seq #(.NUM_WG(NUM_WG), .DLY_W(DLY_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .col_cnt_i  (col_cnt),
    .acc_cnt_i  (acc_cnt),
    .pre_thr_i  (cfg_pre_thr_i),
    .trig_thr_i (cfg_trig_thr_i),
    .delay_i    (cfg_delay_i),
    .acc_en_i   (cfg_acc_en_i),
    .cand_o     (cand)
  );

  stub_rank #(.NUM_WG(NUM_WG), .WG_W(WG_W)) i_rank (
    .cand_i  (cand),
    .best0_o (best0),
    .wg0_o   (wg0),
    .best1_o (best1),
    .wg1_o   (wg1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stub0_valid_o <= 1'b0;
      stub0_wg_o    <= '0;
      stub0_acc_o   <= 1'b0;
      stub0_cnt_o   <= '0;
      stub1_valid_o <= 1'b0;
      stub1_wg_o    <= '0;
      stub1_acc_o   <= 1'b0;
      stub1_cnt_o   <= '0;
    end else begin
      stub0_valid_o <= best0.valid;
      stub0_wg_o    <= wg0;
      stub0_acc_o   <= best0.acc;
      stub0_cnt_o   <= best0.cnt;
      stub1_valid_o <= best1.valid;
      stub1_wg_o    <= wg1;
      stub1_acc_o   <= best1.acc;
      stub1_cnt_o   <= best1.cnt;
    end
  end
endmodule

// File: rtl/anode_stub_finder_chk.sv
module anode_stub_finder_chk #(
  parameter int NUM_WG = 16,
  parameter int DLY_W  = 3,
  parameter int WG_W   = $clog2(NUM_WG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      cfg_trig_thr_i,
  input logic            cfg_acc_en_i,
  input logic            stub0_valid_o,
  input logic [WG_W-1:0] stub0_wg_o,
  input logic            stub0_acc_o,
  input logic [2:0]      stub0_cnt_o,
  input logic            stub1_valid_o,
  input logic [WG_W-1:0] stub1_wg_o,
  input logic            stub1_acc_o,
  input logic [2:0]      stub1_cnt_o
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stub0_valid_o |-> (stub0_cnt_o >= 3'd1) && (stub0_cnt_o <= 3'd6)); // R2

  AST_TRIG_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stub0_valid_o |-> stub0_cnt_o >= cfg_trig_thr_i); // R6

  AST_RANK_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stub1_valid_o |-> (stub0_cnt_o > stub1_cnt_o) ||
                      ((stub0_cnt_o == stub1_cnt_o) && !(stub0_acc_o && !stub1_acc_o))); // R8

  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stub1_valid_o |-> stub0_valid_o); // R9

  AST_SECOND_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stub1_valid_o |-> (int'(stub0_wg_o) > int'(stub1_wg_o) + 1) ||
                      (int'(stub1_wg_o) > int'(stub0_wg_o) + 1)); // R9

  AST_ACC_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_acc_en_i |-> !stub0_acc_o && !stub1_acc_o); // R10

  AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stub0_valid_o |-> (stub0_wg_o == '0) && !stub0_acc_o && (stub0_cnt_o == '0)); // R11
endmodule

bind anode_stub_finder anode_stub_finder_chk #(.NUM_WG(NUM_WG), .DLY_W(DLY_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_trig_thr_i (cfg_trig_thr_i),
  .cfg_acc_en_i   (cfg_acc_en_i),
  .stub0_valid_o  (stub0_valid_o),
  .stub0_wg_o     (stub0_wg_o),
  .stub0_acc_o    (stub0_acc_o),
  .stub0_cnt_o    (stub0_cnt_o),
  .stub1_valid_o  (stub1_valid_o),
  .stub1_wg_o     (stub1_wg_o),
  .stub1_acc_o    (stub1_acc_o),
  .stub1_cnt_o    (stub1_cnt_o)
);

// File: tb/test_anode_stub_finder.sv
module test_anode_stub_finder;
  localparam int CLK_PERIOD = 10;
  localparam int NW    = 12;
  localparam int DW    = 3;
  localparam int NL    = 6;
  localparam int WW    = $clog2(NW);
  localparam int EXP_W = 2 * (1 + WW + 1 + 3);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NL*NW-1:0] hits = '0;
  logic [2:0]      pre_thr = 3'd2, trig_thr = 3'd4;
  logic [DW-1:0]   dly = DW'(1);
  logic            acc_en = 1'b0;
  logic            s0_v, s0_a, s1_v, s1_a;
  logic [WW-1:0]   s0_w, s1_w;
  logic [2:0]      s0_c, s1_c;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int timer [NW];
  logic [EXP_W-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  anode_stub_finder #(.NUM_WG(NW), .DLY_W(DW)) i_anode_stub_finder (
    .clk_i(clk), .rst_ni(rst_ni), .hits_i(hits),
    .cfg_pre_thr_i(pre_thr), .cfg_trig_thr_i(trig_thr), .cfg_delay_i(dly), .cfg_acc_en_i(acc_en),
    .stub0_valid_o(s0_v), .stub0_wg_o(s0_w), .stub0_acc_o(s0_a), .stub0_cnt_o(s0_c),
    .stub1_valid_o(s1_v), .stub1_wg_o(s1_w), .stub1_acc_o(s1_a), .stub1_cnt_o(s1_c)
  );

  function automatic logic [EXP_W-1:0] actual();
    return {s0_v, s0_w, s0_a, s0_c, s1_v, s1_w, s1_a, s1_c};
  endfunction

  task automatic check(input logic [EXP_W-1:0] e);
    n_cmp++;
    if (actual() !== e) begin
      n_bad++;
      $display("FAIL %s: stubs actual %h expected %h", tag, actual(), e);
    end
  endtask

  // behavioural reference: one call per crossing
  task automatic model(input logic [NL*NW-1:0] h, output logic [EXP_W-1:0] e);
    int cv [NW]; int ca [NW]; int cc [NW];
    int i0, i1;
    for (int k = 0; k < NW; k++) begin
      int col = 0, acc = 0;
      bit pre, ev;
      for (int l = 0; l < NL; l++) begin
        bit ch = 0, ah = 0;
        for (int w = k - 1; w <= k + 2; w++) begin
          if (w < 0 || w >= NW || !h[l*NW + w]) continue;
          if (l == 1) begin
            if (w == k) begin ch = 1; ah = 1; end
          end else begin
            if (w <= k + 1) ch = 1;
            if (w >= k) ah = 1;
          end
        end
        col += ch; acc += ah;
      end
      if (!acc_en) acc = 0;
      pre = (timer[k] == 0) && (col >= pre_thr || (acc_en && acc >= pre_thr));
      ev  = (timer[k] == 1) || (pre && dly == 0);
      cv[k] = 0; ca[k] = 0; cc[k] = 0;
      if (ev) begin
        if (col >= trig_thr && (acc < trig_thr || col >= acc)) begin cv[k] = 1; cc[k] = col; end
        else if (acc >= trig_thr) begin cv[k] = 1; ca[k] = 1; cc[k] = acc; end
      end
      if (pre && dly != 0) timer[k] = dly;
      else if (timer[k] > 0) timer[k]--;
    end
    i0 = -1; i1 = -1;
    for (int k = 0; k < NW; k++)
      if (cv[k] && (i0 < 0 || cc[k] > cc[i0] || (cc[k] == cc[i0] && ca[i0] && !ca[k]))) i0 = k;
    if (i0 >= 0)
      for (int k = 0; k < NW; k++)
        if (cv[k] && (k > i0 + 1 || k < i0 - 1) &&
            (i1 < 0 || cc[k] > cc[i1] || (cc[k] == cc[i1] && ca[i1] && !ca[k]))) i1 = k;
    e = '0;
    if (i0 >= 0) e[EXP_W-1 -: EXP_W/2] = {1'b1, WW'(i0), ca[i0][0], 3'(cc[i0])};
    if (i1 >= 0) e[EXP_W/2-1 : 0]      = {1'b1, WW'(i1), ca[i1][0], 3'(cc[i1])};
  endtask

  // one crossing: compare the result due now, then apply new hits (R5 latency: two edges)
  task automatic step(input logic [NL*NW-1:0] h);
    logic [EXP_W-1:0] e;
    @(negedge clk);
    if (exp_q.size() == 2) check(exp_q.pop_front());
    hits = h;
    model(h, e);
    exp_q.push_back(e);
  endtask

  function automatic logic [NL*NW-1:0] rnd_hits(int dens, bit edges_only);
    logic [NL*NW-1:0] h = '0;
    for (int l = 0; l < NL; l++)
      for (int w = 0; w < NW; w++)
        if ((!edges_only || w < 2 || w >= NW - 2) && ($urandom_range(99) < dens)) h[l*NW + w] = 1'b1;
    return h;
  endfunction

  task automatic flush();
    string keep = tag;
    tag = "R11";
    repeat (12) step('0);
    tag = keep;
  endtask

  task automatic phase(input string t, input int p, input int tr, input int d, input bit a,
                       input int dens, input int n, input bit edges);
    flush();
    tag = t;
    pre_thr = 3'(p); trig_thr = 3'(tr); dly = DW'(d); acc_en = a;
    repeat (n) step(rnd_hits(dens, edges));
  endtask

  function automatic logic [NL*NW-1:0] track(int base, bit accel);
    logic [NL*NW-1:0] h = '0;
    for (int l = 0; l < NL; l++) begin
      int w = (l == 1) ? base : (accel ? base + 2 : ((l % 2 == 0) ? base - 1 : base + 1));
      h[l*NW + w] = 1'b1;
    end
    return h;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NW; k++) timer[k] = 0;
    repeat (3) @(negedge clk);
    check('0); // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk);
    check('0); // R1 first cycle after release
    // R2 directed collision track, then random
    tag = "R2";
    repeat (3) step(track(5, 0));
    repeat (4) step('0);
    phase("R2", 2, 4, 1, 0, 8, 400, 0);
    // R3 directed accelerator track, then random
    flush(); tag = "R3"; acc_en = 1'b1;
    repeat (3) step(track(3, 1));
    repeat (4) step('0);
    phase("R3", 2, 4, 1, 1, 8, 400, 0);
    phase("R4", 5, 3, 1, 1, 12, 400, 0);
    phase("R5", 2, 4, 0, 1, 10, 300, 0);
    phase("R5", 2, 4, 3, 0, 10, 300, 0);
    phase("R5", 3, 4, 7, 1, 12, 300, 0);
    phase("R6", 2, 6, 2, 1, 25, 300, 0);
    phase("R6", 1, 1, 1, 0, 3, 300, 0);
    phase("R7", 2, 3, 4, 1, 30, 400, 0);
    phase("R8", 2, 3, 1, 1, 20, 400, 0);
    phase("R9", 3, 3, 2, 1, 15, 400, 0);
    phase("R10", 2, 3, 1, 0, 20, 400, 0);
    phase("R12", 1, 2, 1, 1, 30, 400, 1);
    flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule